// File: doc/BRIEF.md
# Paged Onboard RAM Hit Decoder

This block sits between a CPU's memory strobe and the strobe generator of a board's dynamic RAM. For every memory request it decides whether the access lands in the RAM soldered on the board, or belongs to something else such as ROM, an expansion card or an empty hole. It also produces the most significant column-address bit for the RAM.

The decision depends on four things:

- the top two address bits;
- a page number;
- a mapping mode, either ROM mode or RAM-only mode;
- the board build, which carries either two or four 16 KB RAM pages.

On the four-page build, the column MSB normally follows address bit 15. It is pulled low for one window, which shifts page 1's 8000–BFFFh window onto the lower DRAM region. On the two-page build, the RAM parts are half-good 64K chips. A strap input then pins the column MSB to whichever half works.

Page number, mode and board build are held in registers that load on a strobe. The combinational decode therefore always sees settled values. The hit output is active low, ready to gate a column strobe.

Top module: `pram_hit_decode`

## Requirements
- R1: While `mreq_n` is high, `ram_hit_n` is high (no hit), whatever the other inputs are.
- R2: With `mreq_n` low and `addr_hi` = 2'b11 (`addr_hi[1]` is A15, `addr_hi[0]` is A14), `ram_hit_n` is low for every page, mode and board.
- R3: On the two-page board (`cfg_four_page` = 0), `addr_hi` = 2'b10 is a hit only on page 0. `addr_hi` = 2'b00 and 2'b01 never hit, in either mode.
- R4: On the four-page board in RAM-only mode (`cfg_ram_only` = 1), every `addr_hi` value hits on page 0.
- R5: On the four-page board in ROM mode (`cfg_ram_only` = 0):
  - `addr_hi` = 2'b01 hits on page 0 only;
  - `addr_hi` = 2'b10 hits on page 0 or page 1;
  - `addr_hi` = 2'b00 never hits.
- R6: Any case not covered by R2–R5 gives no hit. This includes page values other than 0 and 1, and page 1 in RAM-only mode.
- R7: On the four-page board, `col_msb` equals `addr_hi[1]`, except in the R8 case.
- R8: On the four-page board, in ROM mode, with page 1 and `addr_hi` = 2'b10, `col_msb` is 0.
- R9: On the two-page board, `col_msb` equals `half_hi` for every address.
- R10: Page, mode and board are captured at a rising clock edge where `cfg_load` is 1, and they are used from that edge on. Without the strobe they hold their values. Reset sets page 0, ROM mode, and the board given by `RST_FOUR_PAGE` (default four-page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for page, mode and board |
| cfg_page | input | PAGE_W | RAM page number to load |
| cfg_ram_only | input | 1 | Mode to load: 1 is RAM-only, 0 is ROM mode |
| cfg_four_page | input | 1 | Board to load: 1 is four-page, 0 is two-page |
| half_hi | input | 1 | Good-half strap for two-page boards: 1 is the upper half |
| addr_hi | input | 2 | Address bits A15 (bit 1) and A14 (bit 0) |
| mreq_n | input | 1 | Active-low memory request |
| ram_hit_n | output | 1 | Active low: the access targets onboard RAM |
| col_msb | output | 1 | Most significant DRAM column-address bit |

## Verification
A vector table walks each 16 KB window under both boards, both modes and page values 0, 1, 2, 5 and 9.

- Page 1 against page 0 separates the ROM-mode 8000h window from the lower windows.
- The same page in RAM-only mode shows that the remap applies to ROM mode only.
- Pages 2, 5 and 9 show that only the common top window survives an unmapped page.
- Two-page vectors with both strap values show that the column bit ignores the address there.

Directed tests look at the reset state and at the boundary of the load strobe. They check that a config change is not seen before the capturing edge and that it is seen after it.

// File: rtl/pram_pkg.sv
package pram_pkg;

   typedef enum logic {
      MODE_ROM      = 1'b0,
      MODE_RAM_ONLY = 1'b1
   } map_mode_e;

   typedef enum logic {
      BOARD_TWO  = 1'b0,
      BOARD_FOUR = 1'b1
   } board_e;

   // 16 KB windows selected by {A15, A14}
   typedef enum logic [1:0] {
      WIN_LO  = 2'b00,
      WIN_MID = 2'b01,
      WIN_HI  = 2'b10,
      WIN_TOP = 2'b11
   } window_e;

endpackage

// File: rtl/pram_cfg_reg.sv
module pram_cfg_reg
   import pram_pkg::*;
#(
   parameter int PAGE_W        = 4,
   parameter bit RST_FOUR_PAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] page_d,
   input  logic              ram_only_d,
   input  logic              four_page_d,
   output logic [PAGE_W-1:0] page_q,
   output map_mode_e         mode_q,
   output board_e            board_q
);

   localparam board_e RST_BOARD = RST_FOUR_PAGE ? BOARD_FOUR : BOARD_TWO;

   // one flop per page bit, each with the shared load enable
   for (genvar b = 0; b < PAGE_W; b++) begin : g_page_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    page_q[b] <= 1'b0;
         else if (load) page_q[b] <= page_d[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_ROM;
         board_q <= RST_BOARD;
      end else if (load) begin
         mode_q  <= ram_only_d  ? MODE_RAM_ONLY : MODE_ROM;
         board_q <= four_page_d ? BOARD_FOUR    : BOARD_TWO;
      end
   end

endmodule

// File: rtl/pram_hit_logic.sv
module pram_hit_logic
   import pram_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic [PAGE_W-1:0] page,
   input  map_mode_e         mode,
   input  board_e            board,
   input  window_e           win,
   input  logic              req,
   output logic              hit
);

   localparam logic [PAGE_W-1:0] PG_ZERO = '0;
   localparam logic [PAGE_W-1:0] PG_ONE  = PAGE_W'(1);

   logic pg0, pg1, map_hit;

   assign pg0 = (page == PG_ZERO);
   assign pg1 = (page == PG_ONE);

   always_comb begin
      map_hit = 1'b0;
      if (win == WIN_TOP) begin
         map_hit = 1'b1;                       // common window
      end else if (board == BOARD_TWO) begin
         map_hit = (win == WIN_HI) && pg0;
      end else if (mode == MODE_RAM_ONLY) begin
         map_hit = pg0;
      end else begin
         unique case (win)
            WIN_MID: map_hit = pg0;
            WIN_HI:  map_hit = pg0 || pg1;
            default: map_hit = 1'b0;           // ROM lives in the low window
         endcase
      end
   end

   assign hit = req && map_hit;

endmodule

// File: rtl/pram_col_logic.sv
module pram_col_logic
   import pram_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic [PAGE_W-1:0] page,
   input  map_mode_e         mode,
   input  board_e            board,
   input  window_e           win,
   input  logic              half_hi,
   output logic              col_msb
);

   localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);

   logic remap;

   // page 1 high window in ROM mode is folded onto the lower DRAM region
   assign remap = (mode == MODE_ROM) && (page == PG_ONE) && (win == WIN_HI);

   always_comb begin
      if (board == BOARD_TWO) col_msb = half_hi;
      else if (remap)         col_msb = 1'b0;
      else                    col_msb = win[1];
   end

endmodule

// File: rtl/pram_hit_decode.sv
module pram_hit_decode
   import pram_pkg::*;
#(
   parameter int PAGE_W        = 4,
   parameter bit RST_FOUR_PAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [PAGE_W-1:0] cfg_page,
   input  logic              cfg_ram_only,
   input  logic              cfg_four_page,
   input  logic              half_hi,
   input  logic [1:0]        addr_hi,
   input  logic              mreq_n,
   output logic              ram_hit_n,
   output logic              col_msb
);

   if (PAGE_W < 1) begin : g_bad_page_w
      $error("pram_hit_decode: PAGE_W must be at least 1");
   end

   logic [PAGE_W-1:0] page_q;
   map_mode_e         mode_q;
   board_e            board_q;
   window_e           win;
   logic              hit;

   assign win = window_e'(addr_hi);

   pram_cfg_reg #(.PAGE_W(PAGE_W), .RST_FOUR_PAGE(RST_FOUR_PAGE)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (cfg_load),
      .page_d      (cfg_page),
      .ram_only_d  (cfg_ram_only),
      .four_page_d (cfg_four_page),
      .page_q      (page_q),
      .mode_q      (mode_q),
      .board_q     (board_q)
   );

   pram_hit_logic #(.PAGE_W(PAGE_W)) u_hit (
      .page  (page_q),
      .mode  (mode_q),
      .board (board_q),
      .win   (win),
      .req   (~mreq_n),
      .hit   (hit)
   );

   pram_col_logic #(.PAGE_W(PAGE_W)) u_col (
      .page    (page_q),
      .mode    (mode_q),
      .board   (board_q),
      .win     (win),
      .half_hi (half_hi),
      .col_msb (col_msb)
   );

   assign ram_hit_n = ~hit;

endmodule

// File: rtl/pram_hit_decode_chk.sv
module pram_hit_decode_chk #(
   parameter int PAGE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_load,
   input logic              mreq_n,
   input logic [1:0]        addr_hi,
   input logic              half_hi,
   input logic              ram_hit_n,
   input logic              col_msb,
   input logic [PAGE_W-1:0] page_q,
   input logic              mode_q,
   input logic              board_q
);

   localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);

   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_n |-> ram_hit_n);                                          // R1

   AST_COMMON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && addr_hi == 2'b11) |-> !ram_hit_n);                  // R2

   AST_TWO_PAGE_LOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (!board_q && !addr_hi[1]) |-> ram_hit_n);                       // R3

   AST_ROM_LOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (board_q && !mode_q && addr_hi == 2'b00) |-> ram_hit_n);         // R5

   AST_REMAP_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (board_q && !mode_q && page_q == PG_ONE && addr_hi == 2'b10) |-> !col_msb); // R8

   AST_HALF_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !board_q |-> (col_msb == half_hi));                             // R9

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(page_q) && $stable(mode_q) && $stable(board_q))); // R10

endmodule

bind pram_hit_decode pram_hit_decode_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_load  (cfg_load),
   .mreq_n    (mreq_n),
   .addr_hi   (addr_hi),
   .half_hi   (half_hi),
   .ram_hit_n (ram_hit_n),
   .col_msb   (col_msb),
   .page_q    (page_q),
   .mode_q    (mode_q),
   .board_q   (board_q)
);

// File: tb/pram_hit_decode_tb.sv
module pram_hit_decode_tb;

   localparam int PAGE_W = 4;
   localparam int NVEC   = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_load = 1'b0;
   logic [PAGE_W-1:0] cfg_page = '0;
   logic              cfg_ram_only = 1'b0;
   logic              cfg_four_page = 1'b0;
   logic              half_hi = 1'b0;
   logic [1:0]        addr_hi = 2'b00;
   logic              mreq_n = 1'b1;
   logic              ram_hit_n;
   logic              col_msb;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pram_hit_decode #(.PAGE_W(PAGE_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_load      (cfg_load),
      .cfg_page      (cfg_page),
      .cfg_ram_only  (cfg_ram_only),
      .cfg_four_page (cfg_four_page),
      .half_hi       (half_hi),
      .addr_hi       (addr_hi),
      .mreq_n        (mreq_n),
      .ram_hit_n     (ram_hit_n),
      .col_msb       (col_msb)
   );

   // {req[3:0], four, ram_only, page[3:0], addr[1:0], mreq_n, half, exp_hit_n, exp_msb}
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd1, 1'b1, 1'b1, 4'd0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 idle
      {4'd2, 1'b0, 1'b0, 4'd5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 two-page, odd page
      {4'd2, 1'b1, 1'b1, 4'd9, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 four-page
      {4'd3, 1'b0, 1'b0, 4'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 page 0 hit
      {4'd3, 1'b0, 1'b0, 4'd1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 page 1 miss
      {4'd3, 1'b0, 1'b0, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 mid miss
      {4'd3, 1'b0, 1'b1, 4'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 low miss ram-only
      {4'd4, 1'b1, 1'b1, 4'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 low
      {4'd4, 1'b1, 1'b1, 4'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 mid
      {4'd5, 1'b1, 1'b0, 4'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 mid page 0
      {4'd8, 1'b1, 1'b0, 4'd1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 remap, R5 hit
      {4'd5, 1'b1, 1'b0, 4'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 high page 0
      {4'd5, 1'b1, 1'b0, 4'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 ROM window
      {4'd5, 1'b1, 1'b0, 4'd1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 mid page 1 miss
      {4'd6, 1'b1, 1'b0, 4'd2, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 page 2
      {4'd6, 1'b1, 1'b1, 4'd1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 ram-only page 1
      {4'd7, 1'b1, 1'b1, 4'd1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1},  // R7 no remap in ram-only
      {4'd9, 1'b0, 1'b0, 4'd0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1}   // R9 strap high
   };

   task automatic check(input int req, input string what, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic load_cfg(input logic four, input logic ro, input logic [PAGE_W-1:0] pg);
      @(negedge clk);
      cfg_four_page = four;
      cfg_ram_only  = ro;
      cfg_page      = pg;
      cfg_load      = 1'b1;
      @(negedge clk);
      cfg_load      = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state: four-page, ROM mode, page 0
      mreq_n = 1'b0; addr_hi = 2'b01; #2;
      check(10, "reset mid window hit", ram_hit_n, 1'b0);
      addr_hi = 2'b00; #2;
      check(10, "reset low window miss", ram_hit_n, 1'b1);
      mreq_n = 1'b1;

      // main table
      for (int i = 0; i < NVEC; i++) begin
         load_cfg(VEC[i][11], VEC[i][10], VEC[i][9:6]);
         addr_hi = VEC[i][5:4];
         mreq_n  = VEC[i][3];
         half_hi = VEC[i][2];
         #2;
         check(int'(VEC[i][15:12]), "table hit_n", ram_hit_n, VEC[i][1]);
         check(int'(VEC[i][15:12]), "table col_msb", col_msb, VEC[i][0]);
         mreq_n = 1'b1;
      end

      // R9: strap low, address sweep on two-page board
      load_cfg(1'b0, 1'b0, 4'd0);
      half_hi = 1'b0;
      for (int a = 0; a < 4; a++) begin
         addr_hi = 2'(a); #2;
         check(9, "strap low col_msb", col_msb, 1'b0);
      end

      // R1: idle on a configuration that hits everywhere
      load_cfg(1'b1, 1'b1, 4'd0);
      mreq_n = 1'b1; addr_hi = 2'b00; #2;
      check(1, "idle ram-only", ram_hit_n, 1'b1);

      // R10: values without the strobe are ignored
      @(negedge clk);
      cfg_page = 4'd3; cfg_four_page = 1'b0; cfg_ram_only = 1'b0;
      repeat (2) @(negedge clk);
      mreq_n = 1'b0; addr_hi = 2'b00; #2;
      check(10, "no-load hold", ram_hit_n, 1'b0);

      // R10: strobed change is not seen before the edge, seen after it
      @(negedge clk);
      cfg_load = 1'b1; #2;
      check(10, "before capture edge", ram_hit_n, 1'b0);
      @(negedge clk);
      cfg_load = 1'b0; #2;
      check(10, "after capture edge", ram_hit_n, 1'b1);
      mreq_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule